// File: doc/BRIEF.md
# Keyed window watchdog

A watchdog counter that runs from an oscillator-rate tick. Software selects a timeout period through a control register and must keep restarting the count before it runs out. If the count expires, the block raises a one-cycle reset request for the reset generator. To restart the count, software writes an arming key (0x55) and then a firing key (0xAA) to a service port. Any other value written there is treated as a fault and also raises the reset request. So is a firing key that was not armed first.

Two further features are optional. The first is window mode. In this mode a service write is accepted only in the final quarter of the period, so software that services too often is caught as well as software that hangs. The second is a freeze bit, which stops the count while a debugger is active. The rate and window fields lock after their first write in normal operation. They stay writable in special mode. A per-write mask bit lets a debugger change only the freeze bit.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0 and the rate, window and freeze fields read 0. The watchdog is disabled while the rate field is 0, and service writes then have no effect.
- R2: Control write bits: [2:0] rate, 3 window, 4 freeze, 7 mask. Rates 1 to 7 give periods of 2^14, 2^16, 2^18, 2^20, 2^22, 2^23 and 2^24 ticks. With no service, `rst_req` is high in the cycle that ends P ticks after the restarting edge.
- R3: An accepted control write with mask 0 and a nonzero rate restarts the period from zero.
- R4: A control write with bit 7 set leaves rate and window unchanged and does not use up the single allowed write. The freeze bit is still written.
- R5: While `special_mode` is 0, only the first control write with mask 0 changes rate and window; later ones are ignored. While `special_mode` is 1, rate and window can be rewritten at any time.
- R6: Writing 0x55 arms the key checker, and it may be repeated. Writing 0xAA while armed restarts the period. Any other value, or 0xAA while not armed, raises `rst_req` in the cycle after the write.
- R7: With window mode on, a service write while the count is below three quarters of the period raises `rst_req`. Writes at or above that point are accepted. After a restart, the window is closed again.
- R8: The count advances only on cycles where `osc_tick` is high.
- R9: With freeze set and `debug_active` high, the count holds.
- R10: Any control write that changes freeze from 0 to 1 restarts the period, masked writes included.
- R11: When the watchdog is enabled, `debug_active` is high, freeze is 0 and `special_mode` is 1, the period becomes 2^24 and window mode is off.
- R12: `rst_req` lasts exactly one cycle, and service writes in that cycle are ignored. Afterwards the count starts again from zero, the key checker is disarmed, and the control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Count enable at oscillator rate |
| special_mode | input | 1 | Special operating mode (no write lock) |
| debug_active | input | 1 | Debugger holds the core |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | DATA_W | Control write data |
| svc_we | input | 1 | Service register write strobe |
| svc_wdata | input | DATA_W | Service write data |
| rst_req | output | 1 | One-cycle system reset request |
| cfg_rate | output | 3 | Current rate field |
| cfg_window | output | 1 | Current window mode bit |
| cfg_freeze | output | 1 | Current freeze bit |

## Verification
Each result has its own latency, measured from the edge that takes in the write:
- Control readback changes at that edge.
- A key or window fault shows on `rst_req` in the cycle that follows that edge.
- An expiry appears exactly P tick-cycles after the edge that restarted the count.
- After a reset pulse, the count restarts one cycle later.

Every expected item carries the index of the cycle in which it is due. A monitor compares items on the falling edge of that cycle. Expiry cases are checked in the cycle just before the due cycle as well as in the due cycle itself.

// File: rtl/kww_pkg.sv
package kww_pkg;
    localparam int RATE_W   = 3;
    localparam int EXP_W    = 5;
    localparam int RATE_LSB = 0;
    localparam int WIN_BIT  = 3;
    localparam int FRZ_BIT  = 4;
    localparam int MASK_BIT = 7;
    localparam logic [EXP_W-1:0] EXP_LONGEST = 5'd24;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              window;
        logic              freeze;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic locked;
    } cfg_state_t;

    function automatic logic [EXP_W-1:0] rate_to_exp(input logic [RATE_W-1:0] rate);
        logic [EXP_W-1:0] e;
        case (rate)
            3'd6:    e = 5'd23;
            3'd7:    e = 5'd24;
            default: e = EXP_W'(14 + 2 * (int'(rate) - 1));
        endcase
        return e;
    endfunction
endpackage

// File: rtl/kww_cfg_reg.sv
module kww_cfg_reg
    import kww_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_q,
    output logic              restart
);
    cfg_state_t st_d, st_q;
    logic       unused_bits;

    assign unused_bits = ^wr_data;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (wr_en) begin
            st_d.cfg.freeze = wr_data[FRZ_BIT];
            if (!st_q.cfg.freeze && wr_data[FRZ_BIT]) begin
                restart = 1'b1;
            end
            if (!wr_data[MASK_BIT] && (special_mode || !st_q.locked)) begin
                st_d.cfg.rate   = wr_data[RATE_LSB +: RATE_W];
                st_d.cfg.window = wr_data[WIN_BIT];
                if (!special_mode) begin
                    st_d.locked = 1'b1;
                end
                if (wr_data[RATE_LSB +: RATE_W] != '0) begin
                    restart = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

    // R5: a locked register ignores rate and window in normal mode
    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !special_mode && st_q.locked)
        |=> ($stable(st_q.cfg.rate) && $stable(st_q.cfg.window)));

    // R4: a masked write keeps rate and window
    p_mask_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MASK_BIT])
        |=> ($stable(st_q.cfg.rate) && $stable(st_q.cfg.window)));
endmodule

// File: rtl/kww_counter.sv
module kww_counter
    import kww_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clear,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             window_open,
    output logic             expire
);
    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [SPAN_W-1:0] span, last, win_lo;

    assign span   = SPAN_W'(1) << exp_sel;
    assign last   = span - SPAN_W'(1);
    assign win_lo = span - (span >> 2);

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (run && tick) begin
            if ({1'b0, cnt_q} >= last) begin
                expire = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    assign window_open = {1'b0, cnt_q} >= win_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: no tick, no progress
    p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(cnt_q));

    // R9: a stopped counter holds
    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !run) |=> $stable(cnt_q));

    // R3: a restart zeroes the count
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/kww_key_check.sv
module kww_key_check #(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] ARM_KEY  = 8'h55,
    parameter logic [DATA_W-1:0] FIRE_KEY = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              window_on,
    input  logic              window_open,
    input  logic              clear,
    output logic              service_ok,
    output logic              fault
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d    = armed_q;
        service_ok = 1'b0;
        fault      = 1'b0;
        if (clear) begin
            armed_d = 1'b0;
        end else if (wr_en) begin
            if (window_on && !window_open) begin
                fault   = 1'b1;
                armed_d = 1'b0;
            end else if (wr_data == ARM_KEY) begin
                armed_d = 1'b1;
            end else if (wr_data == FIRE_KEY && armed_q) begin
                armed_d    = 1'b0;
                service_ok = 1'b1;
            end else begin
                fault   = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R6: an accepted arming key leaves the checker armed
    p_arm_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && !fault && wr_data == ARM_KEY) |=> armed_q);
endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
    import kww_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                CNT_W    = 24,
    parameter logic [DATA_W-1:0] ARM_KEY  = 8'h55,
    parameter logic [DATA_W-1:0] FIRE_KEY = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              special_mode,
    input  logic              debug_active,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              svc_we,
    input  logic [DATA_W-1:0] svc_wdata,
    output logic              rst_req,
    output logic [2:0]        cfg_rate,
    output logic              cfg_window,
    output logic              cfg_freeze
);
    cfg_t             cfg;
    logic             cfg_restart, enabled, override, window_on, run;
    logic             cnt_clear, key_clear, window_open, expire, service_ok, fault;
    logic [EXP_W-1:0] exp_sel;
    logic             rst_d, rst_q;

    kww_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .wr_en(ctl_we), .wr_data(ctl_wdata),
        .cfg_q(cfg), .restart(cfg_restart)
    );

    assign enabled   = cfg.rate != '0;
    assign override  = enabled && debug_active && !cfg.freeze && special_mode;
    assign exp_sel   = override ? EXP_LONGEST : rate_to_exp(cfg.rate);
    assign window_on = cfg.window && !override;
    assign run       = enabled && !(cfg.freeze && debug_active);
    assign key_clear = rst_q || !enabled;
    assign cnt_clear = key_clear || cfg_restart || service_ok;

    kww_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .run(run),
        .clear(cnt_clear), .exp_sel(exp_sel),
        .window_open(window_open), .expire(expire)
    );

    kww_key_check #(.DATA_W(DATA_W), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(svc_we), .wr_data(svc_wdata),
        .window_on(window_on), .window_open(window_open), .clear(key_clear),
        .service_ok(service_ok), .fault(fault)
    );

    always_comb begin
        rst_d = !rst_q && (expire || fault);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= rst_d;
    end

    assign rst_req    = rst_q;
    assign cfg_rate   = cfg.rate;
    assign cfg_window = cfg.window;
    assign cfg_freeze = cfg.freeze;

    // R12: the request is a single-cycle pulse
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: an unknown key value triggers a reset request
    p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_we && cfg_rate != '0 && !rst_req && svc_wdata != ARM_KEY && svc_wdata != FIRE_KEY)
        |=> rst_req);

    // R1: a disabled watchdog never requests reset
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rate == '0) |=> !rst_req);
endmodule

// File: tb/keyed_window_watchdog_bench.sv
module keyed_window_watchdog_bench;
    localparam int P = 1 << 14;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       osc_tick = 1'b1, special_mode = 1'b0, debug_active = 1'b0;
    logic       ctl_we = 1'b0, svc_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00, svc_wdata = 8'h00;
    logic       rst_req, cfg_window, cfg_freeze;
    logic [2:0] cfg_rate;

    keyed_window_watchdog u_keyed_window_watchdog (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .special_mode(special_mode),
        .debug_active(debug_active), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .svc_we(svc_we), .svc_wdata(svc_wdata), .rst_req(rst_req),
        .cfg_rate(cfg_rate), .cfg_window(cfg_window), .cfg_freeze(cfg_freeze)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        bit         chk_rst;
        logic       rst;
        bit         chk_cfg;
        logic [2:0] rate;
        logic       win;
        logic       frz;
        string      tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    task automatic expect_rst(int at, logic v, string tag);
        item_t it;
        it = '{at: at, chk_rst: 1'b1, rst: v, chk_cfg: 1'b0, rate: 3'd0, win: 1'b0, frz: 1'b0, tag: tag};
        sb.push_back(it);
    endtask

    task automatic expect_cfg(int at, logic [2:0] r, logic w, logic f, string tag);
        item_t it;
        it = '{at: at, chk_rst: 1'b0, rst: 1'b0, chk_cfg: 1'b1, rate: r, win: w, frz: f, tag: tag};
        sb.push_back(it);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic ctl_at(int edge_c, logic [7:0] v);
        wait_to(edge_c - 1);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic svc_at(int edge_c, logic [7:0] v);
        wait_to(edge_c - 1);
        svc_we = 1'b1; svc_wdata = v;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    // monitor: compares every item due in the current cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                n_chk++;
                if (sb[i].chk_rst && rst_req !== sb[i].rst) begin
                    n_fail++;
                    $display("FAIL %s: rst_req=%0b expected %0b (cycle %0d)",
                             sb[i].tag, rst_req, sb[i].rst, cyc);
                end
                if (sb[i].chk_cfg && {cfg_rate, cfg_window, cfg_freeze} !==
                    {sb[i].rate, sb[i].win, sb[i].frz}) begin
                    n_fail++;
                    $display("FAIL %s: cfg=%0d/%0b/%0b expected %0d/%0b/%0b (cycle %0d)",
                             sb[i].tag, cfg_rate, cfg_window, cfg_freeze,
                             sb[i].rate, sb[i].win, sb[i].frz, cyc);
                end
                sb.delete(i);
            end
        end
    end

    int t, w, w2, s, a, b, rp, rp1, rp2, f, c, e, d;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t = cyc;
        // R1: reset state and disabled service
        expect_cfg(t + 1, 3'd0, 1'b0, 1'b0, "R1 reset cfg");
        expect_rst(t + 1, 1'b0, "R1 reset rst_req");
        expect_rst(t + 3, 1'b0, "R1 service ignored while disabled");
        expect_rst(t + 4, 1'b0, "R1 service ignored while disabled");
        svc_at(t + 3, 8'h12);

        // R4: masked write leaves fields and does not lock
        w = t + 6;
        expect_cfg(w, 3'd0, 1'b0, 1'b0, "R4 mask keeps rate");
        ctl_at(w, 8'h83);
        w2 = w + 2;
        expect_cfg(w2, 3'd1, 1'b0, 1'b0, "R4 mask did not lock");
        ctl_at(w2, 8'h01);

        // R6 service sequence and R2 expiry timing
        s = w2 + 10000; a = s + 2;
        expect_rst(s, 1'b0, "R6 arm");
        expect_rst(s + 1, 1'b0, "R6 repeated arm");
        expect_rst(a, 1'b0, "R6 fire");
        expect_rst(w2 + P, 1'b0, "R6 service restarted period");
        expect_rst(a + P - 1, 1'b0, "R2 no early expiry");
        expect_rst(a + P, 1'b1, "R2 expiry at 2^14");
        expect_rst(a + P + 1, 1'b0, "R12 single pulse");
        expect_cfg(a + P + 1, 3'd1, 1'b0, 1'b0, "R12 cfg kept");
        svc_at(s, 8'h55);
        svc_at(s + 1, 8'h55);
        svc_at(a, 8'hAA);

        // R5 lock, R6 faults, R10 freeze rise
        b = a + P + 3;
        expect_cfg(b, 3'd1, 1'b0, 1'b0, "R5 locked write ignored");
        ctl_at(b, 8'h0B);
        expect_rst(b + 3, 1'b1, "R6 bad value");
        svc_at(b + 3, 8'h37);
        rp = b + 6;
        expect_rst(rp, 1'b1, "R6 unarmed fire");
        svc_at(rp, 8'hAA);
        f = rp + 5000;
        expect_cfg(f, 3'd1, 1'b0, 1'b1, "R4 masked freeze write");
        expect_rst(rp + 1 + P, 1'b0, "R10 freeze rise restarted");
        expect_rst(f + P - 1, 1'b0, "R12 count restarted after pulse");
        expect_rst(f + P, 1'b1, "R10 expiry from freeze rise");
        ctl_at(f, 8'h90);

        // R5 special rewrite, R3 restart, R7 window
        c = f + P + 2;
        wait_to(c);
        special_mode = 1'b1;
        w = c + 2;
        expect_cfg(w, 3'd1, 1'b1, 1'b1, "R5 special rewrite");
        ctl_at(w, 8'h19);
        w2 = w + 8000;
        ctl_at(w2, 8'h19);
        rp1 = w + 12300;
        expect_rst(rp1, 1'b1, "R3 rewrite restarted, window closed");
        svc_at(rp1, 8'h55);
        rp2 = rp1 + 1 + 12288;
        expect_rst(rp2, 1'b1, "R7 last closed count");
        svc_at(rp2, 8'h55);
        e = rp2 + 1 + 12289;
        expect_rst(e, 1'b0, "R7 first open count");
        expect_rst(e + 1, 1'b0, "R7 fire in window");
        svc_at(e, 8'h55);
        svc_at(e + 1, 8'hAA);
        a = e + 1;
        expect_rst(a + 5, 1'b1, "R7 window closed after service");
        svc_at(a + 5, 8'h55);

        // R8 tick gating
        c = a + 7;
        wait_to(c);
        osc_tick = 1'b0;
        w = c + 2;
        expect_cfg(w, 3'd1, 1'b0, 1'b1, "R8 cfg");
        expect_rst(w + P, 1'b0, "R8 no ticks, no expiry");
        d = w + 17000;
        expect_rst(d + P - 1, 1'b0, "R8 count waits for tick");
        expect_rst(d + P, 1'b1, "R8 expiry after ticks");
        ctl_at(w, 8'h11);
        wait_to(d);
        osc_tick = 1'b1;

        // R9 freeze during debug
        c = d + P + 2;
        wait_to(c);
        debug_active = 1'b1;
        w = c + 2;
        expect_rst(w + P, 1'b0, "R9 frozen");
        ctl_at(w, 8'h11);
        d = w + 17000;
        expect_rst(d + P - 1, 1'b0, "R9 resumes from hold");
        expect_rst(d + P, 1'b1, "R9 expiry after release");
        wait_to(d);
        debug_active = 1'b0;

        // R11 override: longest period, window off
        c = d + P + 2;
        wait_to(c);
        debug_active = 1'b1;
        w = c + 2;
        expect_cfg(w, 3'd1, 1'b1, 1'b0, "R11 cfg");
        ctl_at(w, 8'h09);
        expect_rst(w + 100, 1'b0, "R11 window off");
        expect_rst(w + 101, 1'b0, "R11 fire accepted");
        svc_at(w + 100, 8'h55);
        svc_at(w + 101, 8'hAA);
        a = w + 101;
        expect_rst(a + P, 1'b0, "R11 period beyond 2^14");
        expect_rst(a + P + 1, 1'b0, "R11 period beyond 2^14");
        wait_to(a + P + 3);

        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule